// File: doc/BRIEF.md
# Buffered PWM Generator with Byte-Staged Compare Value

This block produces a pulse-width modulated output from a free-running up-counter, a compare register and a toggle flip-flop. The flip-flop flips when the counter reaches the compare value. It flips again when the counter wraps from its all-ones value back to zero. At that wrap the block also raises a one-cycle period interrupt. The output pin carries the inverse of the flip-flop. The counter width is the parameter `CNT_W`, which defaults to 16 and may be set from 9 to 16.

Software reaches the block through a small 8-bit register port with three addresses. Address 0 takes the compare low byte and address 1 takes the compare high byte. Address 2 is the control register, where bit 0 is run, bit 1 is the initial flip-flop level and bits 4:2 select the counting clock. A compare value is written low byte first and then high byte, into a staging register. While the timer runs, the staged value becomes active only at the counter wrap. While the timer is stopped, the value becomes active at once. Reads always return the staged value.

The clock select codes are 0 (system clock / 128), 1 (/ 32), 2 (/ 8), 3 (every system clock) and 4 (one count per cycle in which `slow_tick` is high). Codes 5 to 7 stop the counting. The counter advances on a registered clock-enable pulse that comes from an internal prescaler.

Top module: `pwm16_gen`

## Requirements
- R1: After reset, `pwm_out` is 1 because the flip-flop is 0, `period_irq` is 0, and reads at addresses 0, 1 and 2 return 0.
- R2: A low-byte write at address 0 followed by a high-byte write at address 1 loads the staged value {high[CNT_W-9:0], low}. Reads at address 0 return staged bits 7:0. Reads at address 1 return staged bits CNT_W-1:8, zero-extended to 8 bits. Read data is registered and appears on the cycle after the address.
- R3: While the timer is stopped, a high-byte write makes the staged value active at once. After a start, the first match toggle comes cmp ticks after counting begins.
- R4: While the timer runs, the active compare value keeps its old value after a new write until the next counter wrap, even though reads already show the new value.
- R5: When the counter advances to a value equal to the active compare value, the flip-flop inverts and the counter keeps counting.
- R6: When the counter wraps from all ones to zero, the flip-flop inverts and `period_irq` is high for exactly one cycle. The period is 2^CNT_W ticks.
- R7: A write to address 2 while the timer is stopped loads the flip-flop from bit 1, so `pwm_out` shows the inverse of that bit. A write to address 2 in the cycle that stops the timer leaves the flip-flop unchanged.
- R8: While the timer is stopped, `pwm_out` holds its level, no interrupt occurs, and the counter restarts from zero on the next start.
- R9: Select code 2 gives one tick every 8 system cycles, code 3 gives a tick every cycle, and code 4 gives one tick per `slow_tick` pulse. Codes 5 to 7 give no ticks.
- R10: If a high-byte write falls in the same cycle as a wrap, the wrap transfers the staged value from before that write. The new value waits for the following wrap.
- R11: With compare value 2^CNT_W-1, the output shows a low pulse exactly one tick wide just before each wrap.
- R12: With compare value 0, the match and wrap toggles fall on the same tick and cancel, so `pwm_out` stays constant while interrupts continue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | Slow-clock count enable, one pulse per count (select code 4) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control |
| wdata | input | 8 | Register write data |
| rd_data | output | 8 | Registered read data for `addr` |
| pwm_out | output | 1 | PWM output, the inverse of the toggle flip-flop |
| period_irq | output | 1 | One-cycle pulse at each counter wrap |

## Verification
The assertions rely on software following the write order. Every high-byte write comes after a low-byte write. A control write that loads the initial level never happens in the same cycle as a toggle, which holds because loading is allowed only while stopped. The interrupt one-cycle check assumes a wrap can never occur on two cycles in a row, which is true for any width of 9 bits or more. The stimulus always writes low then high. It changes the control register only between measurements. It runs a 12-bit instance so that several full periods, including the wrap-collision write, fit in the run. The collision write is timed from the previously observed interrupt.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;
  typedef enum logic [2:0] {
    SEL_DIV128 = 3'd0,
    SEL_DIV32  = 3'd1,
    SEL_DIV8   = 3'd2,
    SEL_FULL   = 3'd3,
    SEL_SLOW   = 3'd4
  } clk_sel_e;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
endpackage

// File: rtl/pwm16_prescaler.sv
module pwm16_prescaler #(
  parameter int DIV_A = 7,
  parameter int DIV_B = 5,
  parameter int DIV_C = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  input  logic       slow_tick,
  output logic       tick
);
  import pwm16_pkg::*;
  localparam int PRE_W = DIV_A;

  logic [PRE_W-1:0] pre_q;
  logic [2:0]       tap;

  localparam int EXPS [3] = '{DIV_A, DIV_B, DIV_C};
  for (genvar g = 0; g < 3; g++) begin : g_tap
    assign tap[g] = &pre_q[EXPS[g]-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      tick  <= 1'b0;
    end else begin
      pre_q <= pre_q + 1'b1;
      case (sel)
        SEL_DIV128: tick <= tap[0];
        SEL_DIV32:  tick <= tap[1];
        SEL_DIV8:   tick <= tap[2];
        SEL_FULL:   tick <= 1'b1;
        SEL_SLOW:   tick <= slow_tick;
        default:    tick <= 1'b0;
      endcase
    end
  end

  // R9
  no_tick_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    (sel > 3'd4 && $past(sel > 3'd4) && !$past(rst)) |-> !tick);
endmodule

// File: rtl/pwm16_regs.sv
module pwm16_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             ovf_commit,
  output logic             run,
  output logic [2:0]       sel,
  output logic             init_load,
  output logic             init_val,
  output logic [CNT_W-1:0] active,
  output logic [7:0]       rd_data
);
  import pwm16_pkg::*;
  localparam int HI_W = CNT_W - 8;

  logic [7:0]       lo_hold_q;
  logic [CNT_W-1:0] staged_q;
  logic [CNT_W-1:0] active_q;
  logic             run_q;
  logic             init_q;
  logic [2:0]       sel_q;
  logic [CNT_W-1:0] new_val;
  logic             lo_wr, hi_wr, ctl_wr;
  logic [7:0]       hi_rd;

  assign lo_wr   = wr_en && (addr == ADDR_LO);
  assign hi_wr   = wr_en && (addr == ADDR_HI);
  assign ctl_wr  = wr_en && (addr == ADDR_CTRL);
  assign new_val = {wdata[HI_W-1:0], lo_hold_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_hold_q <= '0;
      staged_q  <= '0;
      active_q  <= '0;
      run_q     <= 1'b0;
      init_q    <= 1'b0;
      sel_q     <= '0;
    end else begin
      if (lo_wr) lo_hold_q <= wdata;
      if (hi_wr) staged_q <= new_val;
      if (ctl_wr) begin
        run_q  <= wdata[0];
        init_q <= wdata[1];
        sel_q  <= wdata[4:2];
      end
      if (ovf_commit)
        active_q <= staged_q;
      else if (hi_wr && !run_q)
        active_q <= new_val;
    end
  end

  always_comb begin
    hi_rd = '0;
    hi_rd[HI_W-1:0] = staged_q[CNT_W-1:8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (addr)
        ADDR_LO:   rd_data <= staged_q[7:0];
        ADDR_HI:   rd_data <= hi_rd;
        ADDR_CTRL: rd_data <= {3'b000, sel_q, init_q, run_q};
        default:   rd_data <= '0;
      endcase
    end
  end

  assign run       = run_q;
  assign sel       = sel_q;
  assign init_val  = wdata[1];
  assign init_load = ctl_wr && !run_q;
  assign active    = active_q;

  // R4
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !ovf_commit) |=> $stable(active_q));
endmodule

// File: rtl/pwm16_core.sv
module pwm16_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp,
  input  logic             init_load,
  input  logic             init_val,
  output logic             ovf_commit,
  output logic             pwm_out,
  output logic             period_irq
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             ff_q;
  logic             hit, wrap;

  assign cnt_nx     = cnt_q + 1'b1;
  assign hit        = (cnt_nx == cmp);
  assign wrap       = &cnt_q;
  assign ovf_commit = run && tick && wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      ff_q       <= 1'b0;
      period_irq <= 1'b0;
    end else begin
      period_irq <= 1'b0;
      if (!run) begin
        cnt_q <= '0;
      end else if (tick) begin
        cnt_q      <= cnt_nx;
        period_irq <= wrap;
        if (hit ^ wrap) ff_q <= ~ff_q;
      end
      if (init_load) ff_q <= init_val;
    end
  end

  assign pwm_out = ~ff_q;

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    period_irq |=> !period_irq);

  // R6
  irq_clears_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(period_irq) |-> (cnt_q == '0));

  // R8
  stop_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !init_load) |=> $stable(ff_q));
endmodule

// File: rtl/pwm16_gen.sv
module pwm16_gen #(
  parameter int CNT_W = 16,
  parameter int DIV_A = 7,
  parameter int DIV_B = 5,
  parameter int DIV_C = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slow_tick,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rd_data,
  output logic       pwm_out,
  output logic       period_irq
);
  logic             run, tick, init_load, init_val, ovf_commit;
  logic [2:0]       sel;
  logic [CNT_W-1:0] active;

  pwm16_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
    .clk(clk), .rst(rst), .sel(sel), .slow_tick(slow_tick), .tick(tick)
  );

  pwm16_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ovf_commit(ovf_commit), .run(run), .sel(sel), .init_load(init_load),
    .init_val(init_val), .active(active), .rd_data(rd_data)
  );

  pwm16_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .cmp(active),
    .init_load(init_load), .init_val(init_val), .ovf_commit(ovf_commit),
    .pwm_out(pwm_out), .period_irq(period_irq)
  );
endmodule

// File: tb/pwm16_gen_bench.sv
module pwm16_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 12;
  localparam int PER  = 1 << W;
  localparam int WDOG = 195000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slow_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rd_data;
  logic       pwm_out, period_irq;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  int slow_cnt = 0;

  pwm16_gen #(.CNT_W(W)) u_pwm16_gen (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data),
    .pwm_out(pwm_out), .period_irq(period_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    slow_cnt  <= (slow_cnt == 4) ? 0 : slow_cnt + 1;
    slow_tick <= (slow_cnt == 4);
  end

  // entries: {lo, hi, expected read lo, expected read hi}
  localparam logic [31:0] VEC [4] = '{
    32'h34_02_34_02,
    32'hFF_0F_FF_0F,
    32'h5A_AB_5A_0B,
    32'h10_00_10_00
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_irq(output int t);
    do @(negedge clk); while (!period_irq);
    t = cyc;
  endtask

  task automatic wait_fall(output int t);
    logic p;
    p = pwm_out;
    forever begin
      @(negedge clk);
      if (p && !pwm_out) break;
      p = pwm_out;
    end
    t = cyc;
  endtask

  initial begin
    @(posedge clk);
    while (cyc < WDOG) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int v, ts, tf, ti, ti2, tx;
    logic held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwm_out", pwm_out, 1);
    chk("R1 irq", period_irq, 0);
    rd(2'd0, v); chk("R1 rd lo", v, 0);
    rd(2'd2, v); chk("R1 rd ctrl", v, 0);

    // R2 table of stopped writes and readback
    for (int i = 0; i < 4; i++) begin
      wr(2'd0, VEC[i][31:24]);
      wr(2'd1, VEC[i][23:16]);
      rd(2'd0, v); chk("R2 rd lo", v, VEC[i][15:8]);
      rd(2'd1, v); chk("R2 rd hi", v, VEC[i][7:0]);
    end

    // R7 initial level while stopped: ctrl sel=3 init=1 run=0
    wr(2'd2, 8'h0E);
    chk("R7 init one", pwm_out, 0);
    rd(2'd2, v); chk("R7 rd ctrl", v, 8'h0E);
    wr(2'd2, 8'h0C);
    chk("R7 init zero", pwm_out, 1);

    // R4 start with active 0x010, stage 0x100 during first period
    @(negedge clk);
    ts = cyc;
    wr_en = 1'b1; addr = 2'd2; wdata = 8'h0D;
    @(negedge clk); wr_en = 1'b0;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    rd(2'd1, v); chk("R4 rd staged hi", v, 1);
    wait_fall(tf);
    chk("R4 old compare used", (tf - ts) < 64, 1);
    wait_irq(ti);
    // R6 wrap toggle and period
    chk("R6 match to wrap", ti - tf, PER - 16);
    chk("R6 out rises at wrap", pwm_out, 1);
    @(negedge clk);
    chk("R6 irq one cycle", period_irq, 0);
    wait_fall(tf);
    // R5 match at new compare
    chk("R5 match 0x100", tf - ti, 256);

    // R10 stage max, then low 0x20 and collide high write with wrap
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h0F);
    wr(2'd0, 8'h20);
    while (cyc < ti + PER - 1) @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 irq in collision cycle", period_irq, 1);
    chk("R6 period", cyc - ti, PER);
    ti = cyc;
    rd(2'd0, v); chk("R10 staged lo", v, 8'h20);
    rd(2'd1, v); chk("R10 staged hi", v, 0);
    wait_fall(tf);
    chk("R10 old staged active", tf - ti, PER - 1);
    wait_irq(ti);
    // R11 one-tick pulse
    chk("R11 pulse width", ti - tf, 1);
    chk("R11 out high after wrap", pwm_out, 1);
    wait_fall(tf);
    chk("R10 new value next period", tf - ti, 32);

    // R12 compare zero
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wait_irq(ti);
    held = 1'b1;
    for (int k = 0; k < PER + 4; k++) begin
      @(negedge clk);
      if (pwm_out != 1'b1) held = 1'b0;
      if (period_irq) ti2 = cyc;
    end
    chk("R12 output constant", held, 1);
    chk("R12 irq continues", ti2 - ti, PER);

    // R8 stop holds level; init in stop cycle ignored
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h08);
    wait_irq(ti);
    wait_fall(tf);
    wr(2'd2, 8'h0C);
    held = 1'b1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (pwm_out != 1'b0 || period_irq) held = 1'b0;
    end
    chk("R8 hold while stopped", held, 1);
    chk("R7 stop-cycle init ignored", pwm_out, 0);
    wr(2'd2, 8'h0C);
    chk("R7 init after stop", pwm_out, 1);

    // R3 stopped transfer is immediate
    wr(2'd0, 8'h40);
    wr(2'd1, 8'h00);
    @(negedge clk);
    ts = cyc;
    wr_en = 1'b1; addr = 2'd2; wdata = 8'h0D;
    @(negedge clk); wr_en = 1'b0;
    wait_fall(tf);
    chk("R3 immediate compare", tf - ts, 65);

    // R9 divide by 8 (sel=2)
    wr(2'd2, 8'h08);
    wr(2'd2, 8'h09);
    wait_irq(ti);
    wait_irq(ti2);
    chk("R9 div8 period", ti2 - ti, 8 * PER);

    // R9 slow tick (sel=4), one pulse per 5 cycles
    wr(2'd2, 8'h10);
    wr(2'd2, 8'h11);
    wait_irq(ti);
    wait_irq(ti2);
    chk("R9 slow period", ti2 - ti, 5 * PER);

    // R9 invalid select 7 gives no counting
    wr(2'd2, 8'h1C);
    wr(2'd2, 8'h1D);
    held = 1'b1;
    tx = pwm_out;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (period_irq || pwm_out != tx) held = 1'b0;
    end
    chk("R9 invalid select frozen", held, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule